// File: doc/BRIEF.md
# Fixed-Latency Peripheral Bus Requester

This block turns single commands into transfers on a simple peripheral bus that has neither a ready line nor an error line. A command carrying an address, a direction flag and a full data word is offered on a valid/ready port. Each accepted command becomes exactly two bus cycles: a setup cycle that selects the peripheral and presents address, direction and data, then an access cycle that raises the enable strobe. The block then returns to idle, or goes straight into the setup cycle of the next command.

Nothing on the bus can stall or reject a transfer. Read data is taken from the bus in the access cycle whatever its value, and every command is reported complete by a one-cycle done pulse on the response side. The command port applies back-pressure only during a setup cycle: `cmd_ready` is low there and high in every other cycle. A command held on the port during an access cycle is taken on that cycle's closing edge, so transfers can run back to back at one per two cycles. The response side has no back-pressure. The done pulse and its data come at a fixed time, and the consumer must take them in that cycle.

When no transfer is running, the select and enable strobes are low. Address, direction and write data keep the values of the last transfer, so the bus does not toggle while idle.

Top module: `apb_fixed_requester`

## Requirements
- R1: The cycle after a command is accepted (`cmd_valid` and `cmd_ready` both high at a rising edge) is a setup cycle: `bus_sel`=1 and `bus_en`=0, with `bus_addr`, `bus_write` and `bus_wdata` equal to the accepted command's values.
- R2: The cycle after a setup cycle is always an access cycle: `bus_sel`=1 and `bus_en`=1, with address, direction and write data unchanged from setup.
- R3: An access cycle lasts exactly one clock, and no input can extend it. The next cycle is either idle (`bus_sel`=0, `bus_en`=0) or the setup cycle of a command accepted on the closing edge of the access cycle.
- R4: `rsp_done` is high for exactly one cycle per transfer: the cycle right after that transfer's access cycle. It is low in every other cycle.
- R5: At a read's done pulse, `rsp_rdata` equals the value `bus_rdata` had during that read's access cycle. Values of `bus_rdata` in any other cycle are ignored. A write's completion leaves `rsp_rdata` unchanged.
- R6: `cmd_ready` is 1 in idle and access cycles and 0 in setup cycles. A command offered during an access cycle has its setup cycle immediately after that access cycle.
- R7: In idle cycles `bus_sel` and `bus_en` are 0, and `bus_addr`, `bus_write` and `bus_wdata` hold the values of the last transfer.
- R8: Every write drives all DATA_W bits of the command's data on `bus_wdata`. There is no partial-word write.
- R9: An active-low asynchronous reset (`rst_n`=0) at once forces `bus_sel`=0, `bus_en`=0, `rsp_done`=0, `cmd_ready`=1, and `bus_addr`, `bus_write`, `bus_wdata` and `rsp_rdata` to zero. It also abandons any transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_addr | input | ADDR_W | Command address |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_wdata | input | DATA_W | Command write word |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Data captured by the last read |
| bus_sel | output | 1 | Peripheral select strobe |
| bus_en | output | 1 | Access-phase enable strobe |
| bus_write | output | 1 | Bus direction, 1 = write |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_rdata | input | DATA_W | Bus read data, sampled in the access cycle |

## Verification
Every result has a fixed delay after acceptance. The setup strobes and address appear one edge after the accepting edge. The access strobe appears two edges after it. The done pulse and captured read data appear three edges after it, which is also the first idle cycle, or the next setup cycle when commands are offered back to back. The bench drives inputs on falling edges and checks every output on the falling edge of each of these cycles. In all other cycles it puts a varying pattern on `bus_rdata`, so data that is sampled early or late shows up as a wrong value. Idle gaps of zero, one and two cycles between commands exercise each of these delays.

// File: rtl/apbreq_pkg.sv
package apbreq_pkg;
  // Bus phase of the requester; the order encodes the transfer sequence.
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACCESS = 2'd2
  } phase_e;

  localparam int unsigned ADDR_W_DEF = 8;
  localparam int unsigned DATA_W_DEF = 32;
endpackage

// File: rtl/apbreq_phase.sv
module apbreq_phase
  import apbreq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   take,
  output phase_e phase
);
  phase_e phase_nxt;

  always_comb begin
    phase_nxt = phase;
    unique case (phase)
      PH_IDLE:   phase_nxt = take ? PH_SETUP : PH_IDLE;
      PH_SETUP:  phase_nxt = PH_ACCESS;
      PH_ACCESS: phase_nxt = take ? PH_SETUP : PH_IDLE;
      default:   phase_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_nxt;
  end

  // R2: setup never repeats and never falls back to idle
  p_setup_advances_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SETUP) |=> (phase == PH_ACCESS));
endmodule

// File: rtl/apbreq_hold.sv
module apbreq_hold #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              write_in,
  input  logic [DATA_W-1:0] wdata_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic              write_q,
  output logic [DATA_W-1:0] wdata_q
);
  // Loaded only when a command is taken; otherwise the bus stays quiet.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      write_q <= 1'b0;
      wdata_q <= '0;
    end else if (load) begin
      addr_q  <= addr_in;
      write_q <= write_in;
      wdata_q <= wdata_in;
    end
  end
endmodule

// File: rtl/apbreq_resp.sv
module apbreq_resp #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fin,
  input  logic              fin_write,
  input  logic [DATA_W-1:0] rdata_in,
  output logic              done_q,
  output logic [DATA_W-1:0] rdata_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= fin;
      if (fin && !fin_write) rdata_q <= rdata_in;
    end
  end

  // R4: a completion never lasts two cycles
  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/apb_fixed_requester.sv
module apb_fixed_requester
  import apbreq_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned DATA_W = DATA_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_write,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_sel,
  output logic              bus_en,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata
);
  phase_e phase;
  logic   take;

  assign cmd_ready = (phase != PH_SETUP);
  assign take      = cmd_valid && cmd_ready;
  assign bus_sel   = (phase != PH_IDLE);
  assign bus_en    = (phase == PH_ACCESS);

  apbreq_phase u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (take),
    .phase (phase)
  );

  apbreq_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (take),
    .addr_in  (cmd_addr),
    .write_in (cmd_write),
    .wdata_in (cmd_wdata),
    .addr_q   (bus_addr),
    .write_q  (bus_write),
    .wdata_q  (bus_wdata)
  );

  apbreq_resp #(.DATA_W(DATA_W)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .fin       (bus_en),
    .fin_write (bus_write),
    .rdata_in  (bus_rdata),
    .done_q    (rsp_done),
    .rdata_q   (rsp_rdata)
  );

  // R1: an accepted command opens a setup cycle on the next clock
  p_accept_setup_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (bus_sel && !bus_en));

  // R2: setup is followed by access with unchanged address and data
  p_setup_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_en) |=> (bus_sel && bus_en && $stable(bus_addr)
                              && $stable(bus_wdata) && $stable(bus_write)));

  // R3: access lasts one cycle only
  p_access_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_en) |=> !bus_en);

  // R4: completion follows an access cycle
  p_done_after_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> $past(bus_en));

  // R6: no command is taken during setup
  p_ready_low_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_en) |-> !cmd_ready);

  // R7: quiet bus across consecutive idle cycles
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_sel && $past(!bus_sel)) |-> ($stable(bus_addr) && $stable(bus_wdata)
                                       && $stable(bus_write)));

  // R7: enable never without select
  p_en_needs_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en |-> bus_sel);
endmodule

// File: tb/apb_fixed_requester_tb_top.sv
module apb_fixed_requester_tb_top;
  localparam int AW = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [AW-1:0] cmd_addr = '0;
  logic          cmd_write = 1'b0;
  logic [DW-1:0] cmd_wdata = '0;
  logic          rsp_done;
  logic [DW-1:0] rsp_rdata;
  logic          bus_sel, bus_en, bus_write;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata;

  int checks = 0;
  int fails  = 0;
  logic [15:0] cyc = '0;

  logic [DW-1:0] slv_mem [1 << AW];
  logic [DW-1:0] ref_mem [1 << AW];
  bit            pend = 0;
  logic [DW-1:0] pend_exp = '0;
  logic [DW-1:0] last_rd = '0;

  always #4 clk = ~clk;

  apb_fixed_requester #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_write(cmd_write), .cmd_wdata(cmd_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .bus_sel(bus_sel), .bus_en(bus_en), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // Peripheral model: real data only while enabled, a moving pattern otherwise
  always_comb begin
    if (bus_sel && bus_en) bus_rdata = slv_mem[bus_addr];
    else                   bus_rdata = {16'hBAD0, cyc};
  end

  always @(posedge clk) begin
    cyc <= cyc + 16'd1;
    if (bus_sel && bus_en && bus_write) slv_mem[bus_addr] <= bus_wdata;
  end

  function automatic logic [DW-1:0] init_word(input int a);
    return (32'(a) * 32'h0101_0101) ^ 32'h5A5A_0000;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Call on a falling edge while the design is idle or in an access cycle.
  task automatic run_txn(input int a, input bit w, input logic [DW-1:0] d, input int gap);
    logic [AW-1:0] ad;
    ad = AW'(a);
    chk(cmd_ready === 1'b1, "R6 ready before offer", {31'd0, cmd_ready}, 1);
    cmd_valid = 1'b1; cmd_addr = ad; cmd_write = w; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_addr = ~ad; cmd_write = ~w; cmd_wdata = ~d;
    // setup cycle
    chk(bus_sel === 1'b1 && bus_en === 1'b0, "R1 setup strobes",
        {30'd0, bus_sel, bus_en}, 32'd2);
    chk(bus_addr === ad && bus_write === w, "R1 setup addr/dir",
        {23'd0, bus_write, bus_addr}, {23'd0, w, ad});
    chk(bus_wdata === d, "R8 full word on bus", bus_wdata, d);
    chk(cmd_ready === 1'b0, "R6 ready low in setup", {31'd0, cmd_ready}, 0);
    if (pend) begin
      chk(rsp_done === 1'b1, "R4 done after back-to-back access", {31'd0, rsp_done}, 1);
      chk(rsp_rdata === pend_exp, "R5 response data", rsp_rdata, pend_exp);
    end else begin
      chk(rsp_done === 1'b0, "R4 done low in setup", {31'd0, rsp_done}, 0);
    end
    if (w) begin
      ref_mem[a] = d;
      pend_exp = last_rd;
    end else begin
      last_rd = ref_mem[a];
      pend_exp = last_rd;
    end
    pend = 1;
    @(negedge clk);
    // access cycle
    chk(bus_sel === 1'b1 && bus_en === 1'b1, "R2 access strobes",
        {30'd0, bus_sel, bus_en}, 32'd3);
    chk(bus_addr === ad && bus_wdata === d && bus_write === w, "R2 access stable",
        bus_wdata, d);
    chk(rsp_done === 1'b0, "R4 done low in access", {31'd0, rsp_done}, 0);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      chk(bus_sel === 1'b0 && bus_en === 1'b0, "R3 idle after access",
          {30'd0, bus_sel, bus_en}, 0);
      chk(bus_addr === ad && bus_wdata === d && bus_write === w, "R7 idle hold",
          {24'd0, bus_addr}, {24'd0, ad});
      if (g == 0) begin
        chk(rsp_done === 1'b1, "R4 done pulse", {31'd0, rsp_done}, 1);
        chk(rsp_rdata === pend_exp, "R5 response data", rsp_rdata, pend_exp);
        pend = 0;
      end else begin
        chk(rsp_done === 1'b0, "R4 done single cycle", {31'd0, rsp_done}, 0);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) begin
      slv_mem[i] = init_word(i);
      ref_mem[i] = init_word(i);
    end
    #2;
    // R9 reset state
    chk(bus_sel === 1'b0 && bus_en === 1'b0 && rsp_done === 1'b0, "R9 reset strobes",
        {29'd0, bus_sel, bus_en, rsp_done}, 0);
    chk(cmd_ready === 1'b1, "R9 reset ready", {31'd0, cmd_ready}, 1);
    chk(bus_addr === '0 && bus_wdata === '0 && rsp_rdata === '0, "R9 reset data",
        bus_wdata | rsp_rdata, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Writes over 16 addresses with gaps 0,1,2, then read back
    for (int a = 0; a < 16; a++)
      run_txn(a, 1'b1, 32'h9E37_79B9 * 32'(a + 1), a % 3);
    for (int a = 0; a < 16; a++)
      run_txn(a, 1'b0, '0, (a + 1) % 3);
    // Unwritten addresses
    run_txn(200, 1'b0, '0, 1);
    run_txn(255, 1'b0, '0, 0);
    // Full-word patterns, write then read back to back
    run_txn(7, 1'b1, 32'hFFFF_FFFF, 0);
    run_txn(7, 1'b0, '0, 0);
    run_txn(7, 1'b1, 32'h8000_0001, 0);
    run_txn(7, 1'b0, '0, 0);
    run_txn(7, 1'b1, 32'h0000_0000, 0);
    run_txn(9, 1'b0, '0, 0);
    run_txn(7, 1'b0, '0, 2);
    // A write completing must leave read data unchanged
    run_txn(33, 1'b1, 32'h1234_5678, 2);

    // R9 reset in the middle of a transfer
    cmd_valid = 1'b1; cmd_addr = 8'd50; cmd_write = 1'b1; cmd_wdata = 32'hCAFE_F00D;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(bus_sel === 1'b1, "R1 setup before reset", {31'd0, bus_sel}, 1);
    rst_n = 1'b0;
    #1;
    chk(bus_sel === 1'b0 && bus_en === 1'b0, "R9 async reset strobes",
        {30'd0, bus_sel, bus_en}, 0);
    chk(bus_addr === '0 && rsp_rdata === '0 && cmd_ready === 1'b1, "R9 async reset data",
        {24'd0, bus_addr}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    pend = 0;
    last_rd = '0;
    @(negedge clk);
    chk(rsp_done === 1'b0 && bus_sel === 1'b0, "R9 abandoned transfer",
        {30'd0, rsp_done, bus_sel}, 0);
    // The abandoned write never reached the peripheral
    run_txn(50, 1'b0, '0, 1);
    run_txn(33, 1'b0, '0, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule